// File: doc/BRIEF.md
# Peripheral Interrupt Configuration Registers

This block is the interrupt register file of one slave peripheral. It serves up to eight interrupt lines. Each line comes from a raw input, which the block samples every clock. A detector then finds a level condition or an edge on the sampled input. A detection sets a sticky latched bit. The latched bits, gated by the per-line enables, are ORed into one peripheral interrupt output.

Software reaches the block through a simple synchronous byte-wide register port. A write takes effect at the next clock edge. A read returns data combinationally from the address presented in the same cycle. The type register and the two polarity registers sit at consecutive addresses (0x11, 0x12, 0x13), so a three-byte burst covers the whole trigger setup of the peripheral. Enables and latch clearing use write-one strobe registers, so software never needs a read-modify-write to change one line. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `pirq_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every readable register returns 0x00, all lines are disabled and the interrupt output is low.
- R2: The trigger-type register (0x11), the rising/high polarity register (0x12) and the falling/low polarity register (0x13) are written and read back at their offsets. A write to any other offset leaves all three unchanged.
- R3: A read of offset 0x10 returns the raw inputs as they were sampled at the most recent clock edge. A raw change set up before edge k is seen after edge k.
- R4: A line whose type bit is 0 is level-sensitive. It detects in every cycle its sampled input is 1 with its 0x12 bit set, or its sampled input is 0 with its 0x13 bit set. With both bits set it always detects, and with neither set it never detects.
- R5: Writing a 1 to bit n of offset 0x15 enables line n, and writing a 1 to bit n of offset 0x16 disables it. Zero bits leave the enable unchanged. A read of either offset returns the current enable mask.
- R6: Writing a 1 to bit n of offset 0x14 clears latched bit n, and zero bits have no effect. Latched bits are otherwise sticky. Offset 0x18 reads the latched bits, and offset 0x14 reads as 0x00.
- R7: A line whose type bit is 1 is edge-sensitive. Its 0x12 bit detects a 0-to-1 change between two consecutive samples, its 0x13 bit detects a 1-to-0 change, and with both set either change is detected.
- R8: A detection is latched at the clock edge after the sample that causes it. When a detection and a latched-clear hit the same bit in the same cycle, the bit ends up set.
- R9: The interrupt output is high exactly when some line has both its latched bit and its enable set.
- R10: Reads of offsets outside 0x10–0x13, 0x15, 0x16 and 0x18 return 0x00. Register bits above the number of lines read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raw_in | input | NUM_LINES | Raw interrupt inputs, already synchronous to clk |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| irq_out | output | 1 | Peripheral interrupt, OR of latched AND enabled |

## Verification
A register write is visible on a read in the cycle after its clock edge. A raw input change set up before edge k shows in the real-time status after edge k. The latched bit and the interrupt output follow after edge k+1, because one sample register and then the latch lie on that path. The bench holds each input set for one full cycle and compares at the following falling clock edge. Its reference advances its own state once per rising edge, in the same order (detect from the old samples, latch, then shift the samples), so every compare falls in the cycle where the result is due. The comparison covers every register read as well as the interrupt output.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 8;

  // Offsets: type/polarity must stay consecutive for burst access
  localparam logic [ADDR_W-1:0] OFS_RTSTAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_TYPE   = 8'h11;
  localparam logic [ADDR_W-1:0] OFS_POLH   = 8'h12;
  localparam logic [ADDR_W-1:0] OFS_POLL   = 8'h13;
  localparam logic [ADDR_W-1:0] OFS_LCLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ENSET  = 8'h15;
  localparam logic [ADDR_W-1:0] OFS_ENCLR  = 8'h16;
  localparam logic [ADDR_W-1:0] OFS_LSTAT  = 8'h18;

  typedef struct packed {
    logic wr_type;
    logic wr_polh;
    logic wr_poll;
    logic wr_enset;
    logic wr_enclr;
    logic wr_lclr;
  } wr_dec_t;
endpackage

// File: rtl/pirq_rst_sync.sv
module pirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pirq_cfg.sv
module pirq_cfg
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wr_dec_t              wr_dec,
  input  logic [REG_W-1:0]     wdata,
  output logic [NUM_LINES-1:0] type_q,
  output logic [NUM_LINES-1:0] polh_q,
  output logic [NUM_LINES-1:0] poll_q,
  output logic [NUM_LINES-1:0] en_q
);
  logic [NUM_LINES-1:0] wbits;
  logic [NUM_LINES-1:0] en_d;
  logic                 en_ce;

  assign wbits = wdata[NUM_LINES-1:0];

  always_comb begin
    en_d  = en_q;
    en_ce = wr_dec.wr_enset | wr_dec.wr_enclr;
    if (wr_dec.wr_enset) en_d = en_q | wbits;
    if (wr_dec.wr_enclr) en_d = en_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      polh_q <= '0;
      poll_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_dec.wr_type) type_q <= wbits;
      if (wr_dec.wr_polh) polh_q <= wbits;
      if (wr_dec.wr_poll) poll_q <= wbits;
      if (en_ce)          en_q   <= en_d;
    end
  end
endmodule

// File: rtl/pirq_line.sv
module pirq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic is_edge,
  input  logic pol_h,
  input  logic pol_l,
  input  logic clr,
  output logic samp_q,
  output logic lat_q
);
  logic prev_q;
  logic hit;
  logic lat_d;

  always_comb begin
    if (is_edge) hit = (pol_h & samp_q & ~prev_q) | (pol_l & ~samp_q & prev_q);
    else         hit = (pol_h & samp_q) | (pol_l & ~samp_q);
    // detection dominates a simultaneous clear
    lat_d = (lat_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      samp_q <= raw;
      prev_q <= samp_q;
      lat_q  <= lat_d;
    end
  end
endmodule

// File: rtl/pirq_regfile.sv
module pirq_regfile
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] raw_in,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq_out
);
  localparam int unsigned PAD_W = REG_W - NUM_LINES;

  logic                 rst_sync_n;
  wr_dec_t              wr_dec;
  logic [NUM_LINES-1:0] type_q, polh_q, poll_q, en_q;
  logic [NUM_LINES-1:0] samp_q, lat_q, clr_mask;
  logic [NUM_LINES-1:0] rd_bits;

  pirq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  always_comb begin
    wr_dec          = '0;
    wr_dec.wr_type  = reg_we && (reg_addr == OFS_TYPE);
    wr_dec.wr_polh  = reg_we && (reg_addr == OFS_POLH);
    wr_dec.wr_poll  = reg_we && (reg_addr == OFS_POLL);
    wr_dec.wr_enset = reg_we && (reg_addr == OFS_ENSET);
    wr_dec.wr_enclr = reg_we && (reg_addr == OFS_ENCLR);
    wr_dec.wr_lclr  = reg_we && (reg_addr == OFS_LCLR);
    clr_mask        = wr_dec.wr_lclr ? reg_wdata[NUM_LINES-1:0] : '0;
  end

  pirq_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_dec (wr_dec),
    .wdata  (reg_wdata),
    .type_q (type_q),
    .polh_q (polh_q),
    .poll_q (poll_q),
    .en_q   (en_q)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    pirq_line u_line (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .raw     (raw_in[g]),
      .is_edge (type_q[g]),
      .pol_h   (polh_q[g]),
      .pol_l   (poll_q[g]),
      .clr     (clr_mask[g]),
      .samp_q  (samp_q[g]),
      .lat_q   (lat_q[g])
    );
  end

  always_comb begin
    unique case (reg_addr)
      OFS_RTSTAT:           rd_bits = samp_q;
      OFS_TYPE:             rd_bits = type_q;
      OFS_POLH:             rd_bits = polh_q;
      OFS_POLL:             rd_bits = poll_q;
      OFS_ENSET, OFS_ENCLR: rd_bits = en_q;
      OFS_LSTAT:            rd_bits = lat_q;
      default:              rd_bits = '0;
    endcase
  end

  if (PAD_W > 0) begin : g_pad
    assign reg_rdata = {{PAD_W{1'b0}}, rd_bits};
  end else begin : g_nopad
    assign reg_rdata = rd_bits;
  end

  assign irq_out = |(lat_q & en_q);
endmodule

// File: rtl/pirq_regfile_chk.sv
module pirq_regfile_chk
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic [NUM_LINES-1:0] type_q,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] lat_q
);
  AST_TYPE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_TYPE) |=> type_q == $past(reg_wdata[NUM_LINES-1:0])); // R2

  AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == OFS_TYPE) |=> $stable(type_q)); // R2

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_ENSET) |=>
      (en_q & $past(reg_wdata[NUM_LINES-1:0])) == $past(reg_wdata[NUM_LINES-1:0])); // R5

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_ENCLR) |=> (en_q & $past(reg_wdata[NUM_LINES-1:0])) == '0); // R5

  AST_EN_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == OFS_ENSET || reg_addr == OFS_ENCLR)) |=>
      (en_q & ~$past(reg_wdata[NUM_LINES-1:0])) ==
      ($past(en_q) & ~$past(reg_wdata[NUM_LINES-1:0]))); // R5

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == OFS_LCLR) |=> (lat_q & $past(lat_q)) == $past(lat_q)); // R6
endmodule

bind pirq_regfile pirq_regfile_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .type_q    (type_q),
  .en_q      (en_q),
  .lat_q     (lat_q)
);

// File: tb/pirq_regfile_tb.sv
`timescale 1ns/1ps
module pirq_regfile_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] raw_in;
  logic         reg_we;
  logic [7:0]   reg_addr;
  logic [7:0]   reg_wdata;
  logic [7:0]   reg_rdata;
  logic         irq_out;

  int n_vec = 0;
  int n_bad = 0;

  // reference state
  logic [N-1:0] m_rawq = '0, m_rawp = '0, m_type = '0, m_ph = '0, m_pl = '0;
  logic [N-1:0] m_en = '0, m_lat = '0;

  always #2 clk = ~clk;

  pirq_regfile #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h10: return 8'(m_rawq);
      8'h11: return 8'(m_type);
      8'h12: return 8'(m_ph);
      8'h13: return 8'(m_pl);
      8'h15, 8'h16: return 8'(m_en);
      8'h18: return 8'(m_lat);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h10: return "R3";
      8'h11, 8'h12, 8'h13: return "R2";
      8'h15, 8'h16: return "R5";
      8'h18: return "R6/R4/R7/R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [N-1:0] exp_hit();
    logic [N-1:0] lvl, edg;
    lvl = (m_ph & m_rawq) | (m_pl & ~m_rawq);
    edg = (m_ph & m_rawq & ~m_rawp) | (m_pl & ~m_rawq & m_rawp);
    return (m_type & edg) | (~m_type & lvl);
  endfunction

  task automatic compare(input string tag);
    logic [7:0] e;
    e = exp_read(reg_addr);
    n_vec++;
    if (reg_rdata !== e) begin
      n_bad++;
      $display("FAIL %s %s addr=%02h rdata=%02h expected=%02h", tag, req_of(reg_addr),
               reg_addr, reg_rdata, e);
    end
    n_vec++;
    if (irq_out !== |(m_lat & m_en)) begin
      n_bad++;
      $display("FAIL %s R9 irq_out=%0b expected=%0b", tag, irq_out, |(m_lat & m_en));
    end
  endtask

  // one register-port cycle: drive, compare, advance reference at the edge
  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic [N-1:0] r);
    logic [N-1:0] w;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; raw_in = r;
    #1 compare("cyc");
    @(posedge clk);
    w = d[N-1:0];
    m_lat  = (m_lat & ~((we && a == 8'h14) ? w : '0)) | exp_hit();
    m_rawp = m_rawq;
    m_rawq = r;
    if (we) begin
      case (a)
        8'h11: m_type = w;
        8'h12: m_ph   = w;
        8'h13: m_pl   = w;
        8'h15: m_en   = m_en | w;
        8'h16: m_en   = m_en & ~w;
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [10] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14,
                               8'h15, 8'h16, 8'h18, 8'h17, 8'h00};
    logic [N-1:0] r;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h10; reg_wdata = '0; raw_in = '0;
    // R1: reset state on every offset while reset is held
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); reg_addr = addrs[i]; #1 compare("R1-reset");
    end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, addrs[i], 8'h00, '0); // R1 after release

    // R4: level-high line 0, level-low line 1
    step(1'b1, 8'h12, 8'h01, '0);
    step(1'b1, 8'h13, 8'h02, 8'h02);
    step(1'b1, 8'h15, 8'h03, 8'h01);
    step(1'b0, 8'h18, 8'h00, 8'h01);
    step(1'b0, 8'h10, 8'h00, 8'h01);
    // R8: clear line 0 while its level still detects: stays set
    step(1'b1, 8'h14, 8'h03, 8'h01);
    step(1'b0, 8'h18, 8'h00, 8'h03);
    step(1'b1, 8'h14, 8'h03, 8'h03);   // R6 clear
    step(1'b0, 8'h18, 8'h00, 8'h03);
    // R7: edge types, rising on 2, falling on 3, both on 4
    step(1'b1, 8'h11, 8'h1C, 8'h03);
    step(1'b1, 8'h12, 8'h14, 8'h03);
    step(1'b1, 8'h13, 8'h18, 8'h03);
    step(1'b1, 8'h14, 8'hFF, 8'h1F);
    step(1'b0, 8'h18, 8'h00, 8'h1F);
    step(1'b0, 8'h18, 8'h00, 8'h03);
    step(1'b0, 8'h18, 8'h00, 8'h03);
    step(1'b1, 8'h16, 8'hFF, 8'h03);   // R5 disable all, R9 drops
    step(1'b0, 8'h17, 8'h00, 8'h03);   // R10 unmapped
    step(1'b0, 8'h14, 8'h00, 8'h03);   // R10 clear offset reads zero

    // constrained random mix
    r = '0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) r = N'($urandom);
      step($urandom_range(0, 1) == 1, addrs[$urandom_range(0, 9)], 8'($urandom), r);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule